// File: doc/BRIEF.md
# Bottle vending sequencer

This block is the control state machine of a bottle vending unit that sells every bottle at one euro and pays change in ten-cent steps. It watches a coin sensor and three comparison flags produced by an external coin sum register (sum below, equal to or above one euro). From these it commands four things: a bottle release, the payout of a single ten-cent coin, a ten-cent debit of the sum register and a clear of the sum register. The release unit and the change unit each answer with a done signal. The sum arithmetic and the mechanics sit outside the block.

The machine is a Moore machine with seven states: `ST_IDLE` (wait for a coin), `ST_TAKE` (coin being counted), `ST_JUDGE` (sum being compared), `ST_VEND` (release bottle), `ST_CLEAR` (clear sum), `ST_GIVE` (pay out ten cents) and `ST_DEBIT` (debit ten cents). The transitions are: IDLE to TAKE when a coin is seen; TAKE to JUDGE once the coin signal drops; JUDGE to GIVE when the sum is above, to VEND when equal, to IDLE when below, and it stays in JUDGE when no flag is set; VEND to CLEAR on release done; CLEAR to IDLE always; GIVE to DEBIT on change done; DEBIT to JUDGE always. When the sum is too high the machine pays ten cents, debits ten cents and compares again, and repeats until the sum is exactly one euro.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low the machine is held in ST_IDLE and all four command outputs are 0; reset acts at once, without a clock edge.
- R2: The commands are decoded from the state alone, and at most one of them is high in any cycle; in ST_IDLE, ST_TAKE and ST_JUDGE all four are 0.
- R3: A high `coin_in` in ST_IDLE moves to ST_TAKE on the next edge; ST_TAKE is held while `coin_in` stays high and is left for ST_JUDGE on the first edge with `coin_in` low, so a long coin pulse counts once.
- R4: In ST_JUDGE with `sum_below` high (and neither other flag) the machine returns to ST_IDLE and issues no command.
- R5: In ST_JUDGE with `sum_equal` high and `sum_above` low the machine enters ST_VEND; `vend_cmd` stays high, ignoring `coin_in`, until an edge with `vend_done` high, which moves to ST_CLEAR.
- R6: ST_CLEAR raises `clear_cmd` for exactly one cycle, then the machine is in ST_IDLE.
- R7: In ST_JUDGE with `sum_above` high the machine enters ST_GIVE; `change_cmd` stays high until an edge with `change_done` high, which moves to ST_DEBIT.
- R8: ST_DEBIT raises `debit_cmd` for exactly one cycle, then the machine is back in ST_JUDGE, so change is paid in a loop of one coin and one debit per pass.
- R9: The flags are ranked above, then equal, then below; with no flag high ST_JUDGE is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_in | input | 1 | Coin sensor, high while a coin is passing |
| sum_above | input | 1 | Sum register holds more than one euro |
| sum_equal | input | 1 | Sum register holds exactly one euro |
| sum_below | input | 1 | Sum register holds less than one euro |
| vend_done | input | 1 | Bottle release unit has finished |
| change_done | input | 1 | Change unit has paid out one coin |
| vend_cmd | output | 1 | Release one bottle |
| change_cmd | output | 1 | Pay out one ten-cent coin |
| debit_cmd | output | 1 | Debit the sum register by ten cents |
| clear_cmd | output | 1 | Clear the sum register |

## Verification
The properties assume that the sum register updates its flags within the cycle after a coin or a debit. They also assume that the done signals are only read while the matching command is high. They do not assume the flags are mutually exclusive: the ranking in R9 is checked with several flags high at once. The stimulus changes inputs only on the falling clock edge. It raises done signals only in the states that wait for them, and it sets flag combinations as a sum register would present them after each pass of the change loop.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TAKE  = 3'd1,
        ST_JUDGE = 3'd2,
        ST_VEND  = 3'd3,
        ST_CLEAR = 3'd4,
        ST_GIVE  = 3'd5,
        ST_DEBIT = 3'd6
    } vend_state_e;

    localparam int unsigned VEND_NUM_STATES = 7;

    typedef struct packed {
        logic vend;
        logic change;
        logic debit;
        logic clear;
    } vend_cmd_t;

    localparam int unsigned VEND_NUM_CMDS = $bits(vend_cmd_t);

endpackage

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
(
    input  vend_state_e state_i,
    input  logic        coin_i,
    input  logic        above_i,
    input  logic        equal_i,
    input  logic        below_i,
    input  logic        vend_done_i,
    input  logic        change_done_i,
    output vend_state_e next_o
);

    always_comb begin
        next_o = state_i;
        unique case (state_i)
            ST_IDLE:  if (coin_i) next_o = ST_TAKE;
            ST_TAKE:  if (!coin_i) next_o = ST_JUDGE;
            ST_JUDGE: begin
                // ranking: above first, then equal, then below
                if (above_i)      next_o = ST_GIVE;
                else if (equal_i) next_o = ST_VEND;
                else if (below_i) next_o = ST_IDLE;
                else              next_o = ST_JUDGE;
            end
            ST_VEND:  if (vend_done_i) next_o = ST_CLEAR;
            ST_CLEAR: next_o = ST_IDLE;
            ST_GIVE:  if (change_done_i) next_o = ST_DEBIT;
            ST_DEBIT: next_o = ST_JUDGE;
            default:  next_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/vend_outdec.sv
module vend_outdec
    import vend_pkg::*;
(
    input  vend_state_e state_i,
    output vend_cmd_t   cmd_o
);

    always_comb begin
        cmd_o = '0;
        unique case (state_i)
            ST_VEND:  cmd_o.vend   = 1'b1;
            ST_CLEAR: cmd_o.clear  = 1'b1;
            ST_GIVE:  cmd_o.change = 1'b1;
            ST_DEBIT: cmd_o.debit  = 1'b1;
            ST_IDLE, ST_TAKE, ST_JUDGE: cmd_o = '0;
            default:  cmd_o = '0;
        endcase
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic coin_in,
    input  logic sum_above,
    input  logic sum_equal,
    input  logic sum_below,
    input  logic vend_done,
    input  logic change_done,
    output logic vend_cmd,
    output logic change_cmd,
    output logic debit_cmd,
    output logic clear_cmd
);

    vend_state_e state_q;
    vend_state_e state_d;
    vend_cmd_t   cmd;

    vend_next u_next (
        .state_i       (state_q),
        .coin_i        (coin_in),
        .above_i       (sum_above),
        .equal_i       (sum_equal),
        .below_i       (sum_below),
        .vend_done_i   (vend_done),
        .change_done_i (change_done),
        .next_o        (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    vend_outdec u_outdec (
        .state_i (state_q),
        .cmd_o   (cmd)
    );

    assign vend_cmd   = cmd.vend;
    assign change_cmd = cmd.change;
    assign debit_cmd  = cmd.debit;
    assign clear_cmd  = cmd.clear;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        coin_in,
    input logic        sum_above,
    input logic        sum_equal,
    input logic        sum_below,
    input logic        vend_done,
    input logic        change_done,
    input logic        vend_cmd,
    input logic        change_cmd,
    input logic        debit_cmd,
    input logic        clear_cmd,
    input vend_state_e state_q
);

    p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vend_cmd, change_cmd, debit_cmd, clear_cmd}));

    p_take_on_coin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && coin_in) |=> (state_q == ST_TAKE));

    p_take_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE && coin_in) |=> (state_q == ST_TAKE));

    p_below_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && !sum_above && !sum_equal && sum_below)
        |=> (state_q == ST_IDLE && !vend_cmd && !change_cmd && !debit_cmd && !clear_cmd));

    p_equal_vend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && !sum_above && sum_equal) |=> vend_cmd);

    p_vend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vend_cmd && !vend_done) |=> vend_cmd);

    p_vend_to_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vend_cmd && vend_done) |=> clear_cmd);

    p_clear_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> (!clear_cmd && state_q == ST_IDLE));

    p_above_give_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && sum_above) |=> change_cmd);

    p_give_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (change_cmd && !change_done) |=> change_cmd);

    p_give_to_debit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (change_cmd && change_done) |=> debit_cmd);

    p_debit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        debit_cmd |=> (!debit_cmd && state_q == ST_JUDGE));

    p_judge_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && !sum_above && !sum_equal && !sum_below)
        |=> (state_q == ST_JUDGE));

endmodule

bind vend_ctrl vend_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .coin_in     (coin_in),
    .sum_above   (sum_above),
    .sum_equal   (sum_equal),
    .sum_below   (sum_below),
    .vend_done   (vend_done),
    .change_done (change_done),
    .vend_cmd    (vend_cmd),
    .change_cmd  (change_cmd),
    .debit_cmd   (debit_cmd),
    .clear_cmd   (clear_cmd),
    .state_q     (state_q)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coin_in = 1'b0, sum_above = 1'b0, sum_equal = 1'b0, sum_below = 1'b0;
    logic vend_done = 1'b0, change_done = 1'b0;
    logic vend_cmd, change_cmd, debit_cmd, clear_cmd;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // expected {vend, change, debit, clear} after the next rising edge
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    vend_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .coin_in(coin_in),
        .sum_above(sum_above), .sum_equal(sum_equal), .sum_below(sum_below),
        .vend_done(vend_done), .change_done(change_done),
        .vend_cmd(vend_cmd), .change_cmd(change_cmd),
        .debit_cmd(debit_cmd), .clear_cmd(clear_cmd)
    );

    function automatic logic [3:0] outs();
        return {vend_cmd, change_cmd, debit_cmd, clear_cmd};
    endfunction

    task automatic compare(input logic [3:0] exp, input string tag);
        n_checks++;
        if (outs() !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes the outputs expected after the edge
    task automatic cyc(input logic c, input logic ab, input logic eq, input logic bl,
                       input logic vd, input logic cd, input logic [3:0] exp,
                       input string tag);
        @(negedge clk);
        coin_in = c; sum_above = ab; sum_equal = eq; sum_below = bl;
        vend_done = vd; change_done = cd;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected item per rising edge, samples 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: held quiet in reset, across clock edges
        repeat (3) @(negedge clk);
        coin_in = 1'b1;
        @(posedge clk); #1;
        compare(4'b0000, "R1 reset hold");
        @(negedge clk);
        coin_in = 1'b0;
        rst_n = 1'b1;

        // R3, R4: long coin counts once, below returns to idle
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take");
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take held");
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take held");
        cyc(0,0,0,1,0,0, 4'b0000, "R3 judge");
        cyc(0,0,0,1,0,0, 4'b0000, "R4 below to idle");
        cyc(0,0,0,1,0,0, 4'b0000, "R2 idle quiet");

        // R5, R6: exact sum
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take");
        cyc(0,0,1,0,0,0, 4'b0000, "R2 judge quiet");
        cyc(0,0,1,0,0,0, 4'b1000, "R5 equal to vend");
        cyc(1,0,1,0,0,0, 4'b1000, "R5 vend held, coin ignored");
        cyc(0,0,1,0,0,0, 4'b1000, "R5 vend held");
        cyc(0,0,1,0,1,0, 4'b0001, "R6 clear");
        cyc(0,0,0,0,0,0, 4'b0000, "R6 clear one cycle");
        cyc(1,0,0,0,0,0, 4'b0000, "R6 back in idle, take");
        cyc(0,0,0,1,0,0, 4'b0000, "R3 judge");
        cyc(0,0,0,1,0,0, 4'b0000, "R4 below to idle");

        // R7, R8: two passes of the change loop
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take");
        cyc(0,1,0,0,0,0, 4'b0000, "R3 judge");
        cyc(0,1,0,0,0,0, 4'b0100, "R7 above to give");
        cyc(0,1,0,0,0,0, 4'b0100, "R7 give held");
        cyc(0,1,0,0,0,1, 4'b0010, "R8 debit");
        cyc(0,1,0,0,0,0, 4'b0000, "R8 debit one cycle, judge");
        cyc(0,1,0,0,0,0, 4'b0100, "R7 second give");
        cyc(0,1,0,0,0,1, 4'b0010, "R8 second debit");
        cyc(0,0,1,0,0,0, 4'b0000, "R8 back to judge");
        cyc(0,0,1,0,0,0, 4'b1000, "R5 vend after change");
        cyc(0,0,1,0,1,0, 4'b0001, "R6 clear after change");
        cyc(0,0,0,0,0,0, 4'b0000, "R6 idle");

        // R9: ranking and waiting with no flag
        cyc(1,0,0,0,0,0, 4'b0000, "R3 take");
        cyc(0,0,0,0,0,0, 4'b0000, "R3 judge");
        cyc(0,0,0,0,0,0, 4'b0000, "R9 no flag wait");
        cyc(0,0,0,0,0,0, 4'b0000, "R9 no flag wait");
        cyc(0,1,1,1,0,0, 4'b0100, "R9 above wins");
        cyc(0,0,1,1,0,1, 4'b0010, "R8 debit");
        cyc(0,0,1,1,0,0, 4'b0000, "R8 judge");
        cyc(0,0,1,1,0,0, 4'b1000, "R9 equal beats below");

        // R1: asynchronous reset during vend
        @(negedge clk);
        vend_done = 1'b0; sum_equal = 1'b0; sum_below = 1'b0;
        #0.5 rst_n = 1'b0;
        #0.5 compare(4'b0000, "R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1,0,0,0,0,0, 4'b0000, "R1 idle after reset, take");
        cyc(0,0,1,0,0,0, 4'b0000, "R3 judge");
        cyc(0,0,1,0,0,0, 4'b1000, "R1 normal run after reset");
        cyc(0,0,0,0,1,0, 4'b0001, "R6 clear");
        cyc(0,0,0,0,0,0, 4'b0000, "R6 idle");

        @(posedge clk); #2;
        while (exp_q.size() > 0) begin
            @(posedge clk); #2;
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule